// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block holds two single-word mailboxes that carry one data word at a time between two clock domains with no fixed phase or frequency relation. Side A loads the first mailbox and reads the second. Side B loads the second mailbox and reads the first. A mailbox accepts one word. It refuses further loads until the opposite side has consumed that word. Each side therefore sees an active-low full flag for the mailbox it loads. It also sees an active-low "mail waiting" flag for the mailbox it reads.

Each side has a write/read select and a mailbox select. Side A treats a high write/read select as a write. Side B uses the opposite polarity. The read data of each side comes from a mux. With the mailbox select high, the mux shows the incoming mailbox word. With it low, the mux passes through a FIFO output word that arrives on an input. Events cross between the domains as toggles through two-flop synchronizers. Each mailbox has its own reset, which empties it and raises its full flag.

Top module: `mbox_dual_clk`

## Requirements
- R1: An A-side clock edge with `a_wr_sel`=1 and `a_mb_sel`=1, while `a_m1_full_n`=1, stores `a_din` in mailbox 1 and drives `a_m1_full_n` low at that same edge.
- R2: While `a_m1_full_n` is low, A-side mailbox writes are ignored. The stored word stays unchanged and is the one side B later receives.
- R3: Side B consumes mailbox 1 on a B-clock edge with `b_wr_sel`=1 and `b_mb_sel`=1 while `b_m1_full_n`=0. That edge raises `b_m1_full_n`. `a_m1_full_n` rises no earlier than 3 and within 40 A-clock edges of the write.
- R4: A side-B mailbox read while no word is waiting (`b_m1_full_n`=1) has no effect. A word written afterwards keeps `a_m1_full_n` low until it is actually read.
- R5: `b_m1_full_n` goes low once a mailbox-1 word becomes visible in the B domain, and it stays low until that word is read.
- R6: `b_dout` equals the mailbox-1 word when `b_mb_sel`=1 and `b_fifo_q` when `b_mb_sel`=0. `a_dout` likewise selects the mailbox-2 word or `a_fifo_q` by `a_mb_sel`.
- R7: Holding `rst1_n` low for at least four edges of each clock empties mailbox 1 and leaves `a_m1_full_n`=1 and `b_m1_full_n`=1. `rst2_n` does the same for mailbox 2. Neither reset disturbs the other mailbox.
- R8: A stream of words sent through a mailbox arrives complete, in order and unaltered, with unrelated clock periods.
- R9: Mailbox 2 mirrors mailbox 1. A B-side write is `b_wr_sel`=0 with `b_mb_sel`=1. It drives `b_m2_full_n` low, raises the mail-waiting flag `a_m2_full_n` low, and blocks later writes. An A-side read is `a_wr_sel`=0 with `a_mb_sel`=1. It releases the mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| rst1_n | input | 1 | Synchronous active-low reset of mailbox 1, held across both clocks |
| rst2_n | input | 1 | Synchronous active-low reset of mailbox 2, held across both clocks |
| a_wr_sel | input | 1 | Side A operation: 1 write, 0 read |
| a_mb_sel | input | 1 | Side A selects the mailbox (1) or the FIFO path (0) |
| a_din | input | 36 | Side A write data |
| a_fifo_q | input | 36 | FIFO output word offered to side A |
| a_dout | output | 36 | Side A read data |
| a_m1_full_n | output | 1 | Low while mailbox 1 holds an unread word (A domain) |
| a_m2_full_n | output | 1 | Low while a mailbox-2 word waits for side A |
| b_wr_sel | input | 1 | Side B operation: 0 write, 1 read |
| b_mb_sel | input | 1 | Side B selects the mailbox (1) or the FIFO path (0) |
| b_din | input | 36 | Side B write data |
| b_fifo_q | input | 36 | FIFO output word offered to side B |
| b_dout | output | 36 | Side B read data |
| b_m2_full_n | output | 1 | Low while mailbox 2 holds an unread word (B domain) |
| b_m1_full_n | output | 1 | Low while a mailbox-1 word waits for side B |

## Verification
The writer's full flag falls at the write edge itself, so the bench checks it one time step after that edge. The read-side mux is combinational, so the bench compares it one time step after it changes the select, before the next edge. The mail-waiting flag on the reader side needs two reader-clock edges, so the bench polls it at falling edges and reads only once it is low. It then checks that the flag has risen after the read edge. The release of the writer flag passes through a second synchronizer, so the bench counts writer edges until release and checks that count against a window rather than a fixed cycle.

// File: rtl/mbox_pkg.sv
// Package: shared width and word type for the mailbox pair.
// Assumes: every block of the pair uses the same word width.
package mbox_pkg;
    parameter int unsigned MBOX_W      = 36;
    parameter int unsigned SYNC_DEPTH  = 2;
    typedef logic [MBOX_W-1:0] mbox_word_t;
endpackage

// File: rtl/mbox_sync.sv
// Module: mbox_sync - multi-flop level synchronizer with synchronous clear.
// Assumes: the input is a slowly changing level (a toggle), never a pulse.
module mbox_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
// Module: mbox_channel - one single-word mailbox from a writer clock to a
// reader clock. Writes and reads are each tracked by a toggle bit. The
// writer is full while its toggle differs from the synchronized reader
// toggle. The reader sees mail while the synchronized writer toggle differs
// from its own toggle.
// Assumes: rst_n is held low across several edges of both clocks; the word
// register is only rewritten while the mailbox is empty, so the reader
// may sample it directly.
module mbox_channel #(
    parameter int unsigned W      = 36,
    parameter int unsigned STAGES = 2
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    output logic [W-1:0] rd_data,
    output logic         wr_full_n,
    output logic         rd_full_n
);
    logic [W-1:0] word_q;
    logic         wr_tog;
    logic         rd_tog;
    logic         rd_tog_w;
    logic         wr_tog_r;

    // Writer side: capture the word and flip the write toggle when empty.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            word_q <= '0;
            wr_tog <= 1'b0;
        end else if (wr_req && wr_full_n) begin
            word_q <= wr_data;
            wr_tog <= ~wr_tog;
        end
    end

    mbox_sync #(.STAGES(STAGES)) u_rd2w (
        .clk(wclk), .rst_n(rst_n), .d(rd_tog), .q(rd_tog_w)
    );

    mbox_sync #(.STAGES(STAGES)) u_wr2r (
        .clk(rclk), .rst_n(rst_n), .d(wr_tog), .q(wr_tog_r)
    );

    assign wr_full_n = (wr_tog == rd_tog_w);
    assign rd_full_n = (wr_tog_r == rd_tog);

    // Reader side: acknowledge a visible word by matching the write toggle.
    always_ff @(posedge rclk) begin
        if (!rst_n)                     rd_tog <= 1'b0;
        else if (rd_req && !rd_full_n)  rd_tog <= wr_tog_r;
    end

    assign rd_data = word_q;
endmodule

// File: rtl/mbox_dual_clk.sv
// Module: mbox_dual_clk - two opposite-direction mailboxes between clock
// domains A and B, with per-side read muxes between mailbox and FIFO data.
// Assumes: rst1_n/rst2_n are synchronous, low for at least four edges of
// each clock; FIFO output words arrive already registered.
module mbox_dual_clk #(
    parameter int unsigned W      = mbox_pkg::MBOX_W,
    parameter int unsigned STAGES = mbox_pkg::SYNC_DEPTH
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst1_n,
    input  logic         rst2_n,
    input  logic         a_wr_sel,
    input  logic         a_mb_sel,
    input  logic [W-1:0] a_din,
    input  logic [W-1:0] a_fifo_q,
    output logic [W-1:0] a_dout,
    output logic         a_m1_full_n,
    output logic         a_m2_full_n,
    input  logic         b_wr_sel,
    input  logic         b_mb_sel,
    input  logic [W-1:0] b_din,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_dout,
    output logic         b_m2_full_n,
    output logic         b_m1_full_n
);
    logic         a_box_wr, a_box_rd, b_box_wr, b_box_rd;
    logic [W-1:0] m1_word, m2_word;

    // Side A writes when its select is high; side B writes when it is low.
    assign a_box_wr = a_mb_sel &  a_wr_sel;
    assign a_box_rd = a_mb_sel & ~a_wr_sel;
    assign b_box_wr = b_mb_sel & ~b_wr_sel;
    assign b_box_rd = b_mb_sel &  b_wr_sel;

    mbox_channel #(.W(W), .STAGES(STAGES)) u_box1 (
        .wclk(clk_a), .rclk(clk_b), .rst_n(rst1_n),
        .wr_req(a_box_wr), .wr_data(a_din),
        .rd_req(b_box_rd), .rd_data(m1_word),
        .wr_full_n(a_m1_full_n), .rd_full_n(b_m1_full_n)
    );

    mbox_channel #(.W(W), .STAGES(STAGES)) u_box2 (
        .wclk(clk_b), .rclk(clk_a), .rst_n(rst2_n),
        .wr_req(b_box_wr), .wr_data(b_din),
        .rd_req(a_box_rd), .rd_data(m2_word),
        .wr_full_n(b_m2_full_n), .rd_full_n(a_m2_full_n)
    );

    // Read-data muxes: mailbox word or FIFO output per side.
    always_comb begin
        a_dout = a_mb_sel ? m2_word : a_fifo_q;
        b_dout = b_mb_sel ? m1_word : b_fifo_q;
    end
endmodule

// File: rtl/mbox_dual_clk_chk.sv
// Module: mbox_dual_clk_chk - protocol properties of the mailbox pair,
// bound into mbox_dual_clk.
module mbox_dual_clk_chk #(
    parameter int unsigned W = mbox_pkg::MBOX_W
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         rst1_n,
    input logic         rst2_n,
    input logic         a_wr_sel,
    input logic         a_mb_sel,
    input logic         b_wr_sel,
    input logic         b_mb_sel,
    input logic         a_m1_full_n,
    input logic         b_m1_full_n,
    input logic         a_m2_full_n,
    input logic         b_m2_full_n,
    input logic [W-1:0] m1_word,
    input logic [W-1:0] m2_word
);
    AST_M1_FULL_ON_WRITE: assert property (@(posedge clk_a) disable iff (!rst1_n)
        (a_wr_sel && a_mb_sel && a_m1_full_n) |=> !a_m1_full_n); // R1
    AST_M1_HOLD_WHILE_FULL: assert property (@(posedge clk_a) disable iff (!rst1_n)
        !a_m1_full_n |=> $stable(m1_word)); // R2
    AST_M1_PENDING_IMPLIES_FULL: assert property (@(posedge clk_b) disable iff (!rst1_n)
        !b_m1_full_n |-> !a_m1_full_n); // R5
    AST_M1_RESET_EMPTIES: assert property (@(posedge clk_a)
        !rst1_n |=> a_m1_full_n); // R7
    AST_M2_FULL_ON_WRITE: assert property (@(posedge clk_b) disable iff (!rst2_n)
        (!b_wr_sel && b_mb_sel && b_m2_full_n) |=> !b_m2_full_n); // R9
    AST_M2_HOLD_WHILE_FULL: assert property (@(posedge clk_b) disable iff (!rst2_n)
        !b_m2_full_n |=> $stable(m2_word)); // R9
    AST_M2_RESET_EMPTIES: assert property (@(posedge clk_b)
        !rst2_n |=> b_m2_full_n); // R7
    AST_M2_PENDING_IMPLIES_FULL: assert property (@(posedge clk_a) disable iff (!rst2_n)
        !a_m2_full_n |-> !b_m2_full_n); // R9
endmodule

bind mbox_dual_clk mbox_dual_clk_chk #(.W(W)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n),
    .a_wr_sel(a_wr_sel), .a_mb_sel(a_mb_sel),
    .b_wr_sel(b_wr_sel), .b_mb_sel(b_mb_sel),
    .a_m1_full_n(a_m1_full_n), .b_m1_full_n(b_m1_full_n),
    .a_m2_full_n(a_m2_full_n), .b_m2_full_n(b_m2_full_n),
    .m1_word(m1_word), .m2_word(m2_word)
);

// File: tb/mbox_dual_clk_tb_top.sv
// Bench: scoreboard queues per mailbox; sender tasks push words, receiver
// tasks pop and compare as words emerge on the opposite side.
module mbox_dual_clk_tb_top;
    localparam int unsigned W            = mbox_pkg::MBOX_W;
    localparam int unsigned CLK_A_PERIOD = 10;
    localparam int unsigned CLK_B_PERIOD = 14;
    localparam int unsigned N_WORDS      = 20;

    logic         clk_a, clk_b, rst1_n, rst2_n;
    logic         a_wr_sel, a_mb_sel, b_wr_sel, b_mb_sel;
    logic [W-1:0] a_din, a_fifo_q, b_din, b_fifo_q, a_dout, b_dout;
    logic         a_m1_full_n, a_m2_full_n, b_m1_full_n, b_m2_full_n;

    int           total = 0;
    int           bad   = 0;
    logic [W-1:0] q1[$];
    logic [W-1:0] q2[$];

    mbox_dual_clk dut_i (
        .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n),
        .a_wr_sel(a_wr_sel), .a_mb_sel(a_mb_sel), .a_din(a_din),
        .a_fifo_q(a_fifo_q), .a_dout(a_dout),
        .a_m1_full_n(a_m1_full_n), .a_m2_full_n(a_m2_full_n),
        .b_wr_sel(b_wr_sel), .b_mb_sel(b_mb_sel), .b_din(b_din),
        .b_fifo_q(b_fifo_q), .b_dout(b_dout),
        .b_m2_full_n(b_m2_full_n), .b_m1_full_n(b_m1_full_n)
    );

    initial begin clk_a = 1'b0; forever #(CLK_A_PERIOD/2) clk_a = ~clk_a; end
    initial begin clk_b = 1'b0; forever #(CLK_B_PERIOD/2) clk_b = ~clk_b; end

    function automatic logic [W-1:0] rnd_word();
        return W'({$urandom(), $urandom()});
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Single mailbox-1 write from side A, no checks.
    task automatic a_put(input logic [W-1:0] w);
        @(negedge clk_a); a_wr_sel = 1'b1; a_mb_sel = 1'b1; a_din = w;
        @(negedge clk_a); a_mb_sel = 1'b0; a_wr_sel = 1'b0;
    endtask

    // Single mailbox-2 write from side B, no checks.
    task automatic b_put(input logic [W-1:0] w);
        @(negedge clk_b); b_wr_sel = 1'b0; b_mb_sel = 1'b1; b_din = w;
        @(negedge clk_b); b_mb_sel = 1'b0; b_wr_sel = 1'b1;
    endtask

    // Driver for mailbox 1: write, try a blocked overwrite, time the release.
    task automatic a_send(input int n);
        for (int i = 0; i < n; i++) begin
            logic [W-1:0] w;
            int waited;
            w = rnd_word();
            @(negedge clk_a);
            while (!a_m1_full_n) @(negedge clk_a);
            a_wr_sel = 1'b1; a_mb_sel = 1'b1; a_din = w;
            q1.push_back(w);
            @(posedge clk_a); #1;
            chk(!a_m1_full_n, "R1 full after write", W'(a_m1_full_n), '0);
            @(negedge clk_a); a_din = ~w;
            @(posedge clk_a); #1;
            chk(!a_m1_full_n, "R2 still full after blocked write", W'(a_m1_full_n), '0);
            @(negedge clk_a); a_mb_sel = 1'b0; a_wr_sel = 1'b0; a_fifo_q = rnd_word(); #1;
            chk(a_dout == a_fifo_q, "R6 a_dout fifo path", a_dout, a_fifo_q);
            waited = 2;
            while (!a_m1_full_n && waited < 60) begin
                @(posedge clk_a); #1; waited++;
            end
            chk(waited >= 3 && waited <= 40, "R3 release window", W'(waited), W'(3));
        end
    endtask

    // Monitor for mailbox 1 on side B: pop and compare each waiting word.
    task automatic b_recv(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge clk_b);
            b_wr_sel = 1'b1; b_mb_sel = 1'b0; b_fifo_q = rnd_word(); #1;
            chk(b_dout == b_fifo_q, "R6 b_dout fifo path", b_dout, b_fifo_q);
            if (!b_m1_full_n) begin
                logic [W-1:0] exp;
                b_mb_sel = 1'b1; #1;
                exp = (q1.size() > 0) ? q1.pop_front() : '0;
                chk(b_dout == exp, "R8 mailbox1 word", b_dout, exp);
                @(posedge clk_b); #1;
                chk(b_m1_full_n, "R3 b_m1_full_n high after read", W'(b_m1_full_n), W'(1));
                got++;
            end
        end
        @(negedge clk_b); b_mb_sel = 1'b0;
    endtask

    // Driver for mailbox 2 on side B.
    task automatic b_send(input int n);
        for (int i = 0; i < n; i++) begin
            logic [W-1:0] w;
            int waited;
            w = rnd_word();
            @(negedge clk_b);
            while (!b_m2_full_n) @(negedge clk_b);
            b_wr_sel = 1'b0; b_mb_sel = 1'b1; b_din = w;
            q2.push_back(w);
            @(posedge clk_b); #1;
            chk(!b_m2_full_n, "R9 full after write", W'(b_m2_full_n), '0);
            @(negedge clk_b); b_din = ~w;
            @(posedge clk_b); #1;
            chk(!b_m2_full_n, "R9 blocked write ignored", W'(b_m2_full_n), '0);
            @(negedge clk_b); b_mb_sel = 1'b0; b_wr_sel = 1'b1;
            waited = 2;
            while (!b_m2_full_n && waited < 60) begin
                @(posedge clk_b); #1; waited++;
            end
            chk(waited >= 3 && waited <= 40, "R9 release window", W'(waited), W'(3));
        end
    endtask

    // Monitor for mailbox 2 on side A.
    task automatic a_recv(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge clk_a);
            a_wr_sel = 1'b0; a_mb_sel = 1'b0;
            if (!a_m2_full_n) begin
                logic [W-1:0] exp;
                a_mb_sel = 1'b1; #1;
                exp = (q2.size() > 0) ? q2.pop_front() : '0;
                chk(a_dout == exp, "R8 mailbox2 word", a_dout, exp);
                @(posedge clk_a); #1;
                chk(a_m2_full_n, "R9 a_m2_full_n high after read", W'(a_m2_full_n), W'(1));
                got++;
            end
        end
        @(negedge clk_a); a_mb_sel = 1'b0;
    endtask

    initial begin
        #(CLK_A_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] w0;
        rst1_n = 1'b0; rst2_n = 1'b0;
        a_wr_sel = 1'b0; a_mb_sel = 1'b0; a_din = '0; a_fifo_q = '0;
        b_wr_sel = 1'b1; b_mb_sel = 1'b0; b_din = '0; b_fifo_q = '0;
        repeat (8) @(negedge clk_b);
        @(negedge clk_a); rst1_n = 1'b1; rst2_n = 1'b1; #1;
        chk(a_m1_full_n && b_m1_full_n, "R7 reset state mailbox1",
            W'({a_m1_full_n, b_m1_full_n}), W'(3));
        chk(a_m2_full_n && b_m2_full_n, "R7 reset state mailbox2",
            W'({a_m2_full_n, b_m2_full_n}), W'(3));

        // R4: reads of an empty mailbox leave no trace.
        @(negedge clk_b); b_wr_sel = 1'b1; b_mb_sel = 1'b1;
        repeat (4) @(negedge clk_b);
        b_mb_sel = 1'b0;
        w0 = rnd_word();
        q1.push_back(w0);
        a_put(w0);
        repeat (12) @(negedge clk_a);
        chk(!a_m1_full_n, "R4 empty read had no effect", W'(a_m1_full_n), '0);
        chk(!b_m1_full_n, "R5 word visible on side B", W'(b_m1_full_n), '0);
        b_recv(1);

        // Streams in each direction, unrelated clocks.
        fork
            a_send(N_WORDS);
            b_recv(N_WORDS);
        join
        fork
            b_send(N_WORDS);
            a_recv(N_WORDS);
        join

        // R7: per-mailbox resets with words pending in both.
        b_put(rnd_word());
        a_put(rnd_word());
        repeat (6) @(negedge clk_b);
        @(negedge clk_a); rst1_n = 1'b0;
        repeat (8) @(negedge clk_b);
        @(negedge clk_a); rst1_n = 1'b1; #1;
        chk(a_m1_full_n && b_m1_full_n, "R7 rst1_n empties mailbox1",
            W'({a_m1_full_n, b_m1_full_n}), W'(3));
        chk(!a_m2_full_n && !b_m2_full_n, "R7 rst1_n leaves mailbox2",
            W'({a_m2_full_n, b_m2_full_n}), '0);
        repeat (10) @(negedge clk_b);
        chk(b_m1_full_n, "R7 no stale mailbox1 word", W'(b_m1_full_n), W'(1));
        @(negedge clk_a); rst2_n = 1'b0;
        repeat (8) @(negedge clk_b);
        @(negedge clk_a); rst2_n = 1'b1; #1;
        chk(a_m2_full_n && b_m2_full_n, "R7 rst2_n empties mailbox2",
            W'({a_m2_full_n, b_m2_full_n}), W'(3));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule